// File: doc/BRIEF.md
# Alternating Fast/Slow Line Timebase for a Line-Scan Sensor

This block sets the line timing for a line-scan image sensor whose stored pixel rate is limited by the speed of the memory behind it. A long exposure at the slow, storable pixel rate would stretch the integration time too far. The block therefore alternates two line timebases. A fast line reads the sensor out quickly, and that read clears the charge left from the previous exposure, so its pixels are marked for discard. A slow line follows. Its integration time is a whole multiple of the fast line's, and it reads out at a pixel rate the downstream store can accept, so its pixels are marked to keep.

The block runs from the master clock. It takes a base pixel divider, a line length in pixels and a ratio between the slow and fast timebases. It drives a pixel clock enable, a one-cycle transfer-gate pulse on the first cycle of every line, a per-line discard flag and a strobe on the first pixel of each line. New configuration values are taken only at the start of a fast/slow pair. A ratio of 1 turns off the alternation, and every line is then a kept line.

Top module: `ita_timebase`

## Requirements
- R1: The configuration inputs are sampled on every clock edge while `rst_n` is low. The first cycle after reset is the first cycle of a line: `tg_pulse_o` is 1, and `discard_o` is 1 when the effective ratio is above 1.
- R2: A base divider of 0 is treated as 1, a ratio of 0 is treated as 1, and a line length of 0 is treated as 1 pixel.
- R3: The kept-line pixel period is never below 6 cycles. The fast pixel period is f = max(effective base divider, ceil(6 / effective ratio)), and the kept-line pixel period is f times the effective ratio.
- R4: On a discard line, `pix_en_o` pulses once every f cycles. On a kept line it pulses once every f×ratio cycles. A line therefore lasts L×f cycles or L×f×ratio cycles, where L is the effective line length. Each pulse falls on the last cycle of its pixel period.
- R5: With an effective ratio above 1, the lines alternate, starting with a discard line: the discard line has `discard_o` = 1 and the kept line has `discard_o` = 0.
- R6: With an effective ratio of 1, every line is a kept line and `discard_o` stays 0.
- R7: `tg_pulse_o` is 1 exactly on the first cycle of each line. `discard_o` changes value only on a cycle where `tg_pulse_o` is 1.
- R8: Each line carries exactly L pulses of `pix_en_o`. `line_start_o` is 1 only together with the first of those pulses.
- R9: A change on the configuration inputs takes effect only at the first line of the next pair: the line that follows a kept line. Changes made during a pair have no effect on the current pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_div_i | input | DIV_W | Base pixel divider (fast-line pixel period, in cycles) |
| line_len_i | input | LEN_W | Pixels per line |
| ita_i | input | ITA_W | Ratio of the slow timebase to the fast timebase |
| pix_en_o | output | 1 | Pixel clock enable, one cycle per pixel |
| tg_pulse_o | output | 1 | Transfer-gate pulse on the first cycle of each line |
| discard_o | output | 1 | 1 while the current line's pixels are to be dropped |
| line_start_o | output | 1 | Strobe on the first pixel enable of each line |

## Verification
A wrong divider count or a wrong latched configuration shows up as a misplaced `pix_en_o` within the first pixel period after the fault, and as a line whose length is off at the next `tg_pulse_o`. A wrong phase register turns `discard_o` the wrong way on the very next line boundary. A fault in the pair-start latch shows up as the period changing in the middle of a pair. The bench compares every output on every cycle against an arithmetic model over a sweep of divider, ratio and line length. It changes the configuration part-way through each run, so that mid-pair changes are exercised.

// File: rtl/ita_pkg.sv
// Package: shared types and helpers for the alternating line timebase.
// Assumes: nothing beyond standard SystemVerilog.
package ita_pkg;

    // Which timebase the current line uses.
    typedef enum logic {
        PH_SLOW = 1'b0,
        PH_FAST = 1'b1
    } phase_e;

endpackage

// File: rtl/ita_cfg_latch.sv
// Module: ita_cfg_latch
// Holds the configuration used by the current fast/slow pair. It clamps
// the zero values, raises the fast divider so that the kept-line period
// is at least MIN_KEEP cycles, and takes new values during reset or
// when load_i is high.
// Assumes: MIN_KEEP fits in DIV_W bits; load_i is high only on the
// cycle that ends a kept line.
module ita_cfg_latch #(
    parameter int DIV_W    = 4,
    parameter int LEN_W    = 8,
    parameter int ITA_W    = 3,
    parameter int MIN_KEEP = 6,
    localparam int SDIV_W  = DIV_W + ITA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DIV_W-1:0]  base_div_i,
    input  logic [LEN_W-1:0]  line_len_i,
    input  logic [ITA_W-1:0]  ita_i,
    output logic [SDIV_W-1:0] fast_div_o,
    output logic [SDIV_W-1:0] slow_div_o,
    output logic [LEN_W-1:0]  last_pix_o,
    output logic              split_o,
    output logic              split_next_o
);

    logic [SDIV_W-1:0] ita_eff;
    logic [SDIV_W-1:0] base_eff;
    logic [SDIV_W-1:0] min_fast;
    logic [SDIV_W-1:0] fast_new;
    logic [SDIV_W-1:0] slow_new;
    logic [LEN_W-1:0]  last_new;

    // Purpose: clamp the inputs and derive the divider pair they ask for.
    always_comb begin
        ita_eff  = (ita_i == '0) ? SDIV_W'(1) : SDIV_W'(ita_i);
        base_eff = (base_div_i == '0) ? SDIV_W'(1) : SDIV_W'(base_div_i);
        min_fast = (SDIV_W'(MIN_KEEP) + ita_eff - SDIV_W'(1)) / ita_eff;
        fast_new = (base_eff > min_fast) ? base_eff : min_fast;
        slow_new = fast_new * ita_eff;
        last_new = (line_len_i == '0) ? '0 : line_len_i - LEN_W'(1);
    end

    assign split_next_o = (ita_eff > SDIV_W'(1));

    // Purpose: take the derived configuration during reset or at a pair start.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            fast_div_o <= fast_new;
            slow_div_o <= slow_new;
            last_pix_o <= last_new;
            split_o    <= split_next_o;
        end
    end

    // R3: the kept-line pixel period never drops below the storage limit
    assert_keep_period_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slow_div_o >= SDIV_W'(MIN_KEEP));

    // R4: the slow period is a whole multiple of the fast period
    assert_slow_multiple_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_div_o % fast_div_o) == '0);

    // R9: the configuration holds still unless a pair start loads it
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(slow_div_o) && $stable(fast_div_o) && $stable(last_pix_o)));

endmodule

// File: rtl/ita_pix_div.sv
// Module: ita_pix_div
// Free-running pixel divider. It raises pix_en_o on the last cycle of
// each period of period_i cycles.
// Assumes: period_i is at least 1 and changes only on the cycle after
// pix_en_o, so a period is never cut short.
module ita_pix_div #(
    parameter int SDIV_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SDIV_W-1:0] period_i,
    output logic              pix_en_o
);

    logic [SDIV_W-1:0] div_cnt;

    assign pix_en_o = (div_cnt == period_i - SDIV_W'(1));

    // Purpose: count the cycles in a pixel period and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || pix_en_o) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + SDIV_W'(1);
        end
    end

    // R4: the counter stays inside the period chosen for the current line
    assert_div_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < period_i);

endmodule

// File: rtl/ita_line_ctr.sv
// Module: ita_line_ctr
// Counts the pixels of a line. It flags the last pixel enable of the
// line and marks the first cycle of each line, which is the transfer
// pulse.
// Assumes: last_pix_i changes only on the cycle after a line end.
module ita_line_ctr #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en_i,
    input  logic [LEN_W-1:0] last_pix_i,
    output logic             line_end_o,
    output logic             first_pix_o,
    output logic             tg_pulse_o
);

    logic [LEN_W-1:0] pix_cnt;
    logic             first_q;

    assign line_end_o  = pix_en_i && (pix_cnt == last_pix_i);
    assign first_pix_o = (pix_cnt == '0);
    assign tg_pulse_o  = first_q;

    // Purpose: advance the pixel index on each pixel enable, wrap at line end.
    always_ff @(posedge clk) begin
        if (!rst_n || line_end_o) begin
            pix_cnt <= '0;
        end else if (pix_en_i) begin
            pix_cnt <= pix_cnt + LEN_W'(1);
        end
    end

    // Purpose: mark the first cycle of the next line after reset or a line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
        end else begin
            first_q <= line_end_o;
        end
    end

    // R8: the pixel index never runs past the last pixel of the line
    assert_pix_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_cnt <= last_pix_i);

    // R7: a line end is always followed by a transfer pulse
    assert_tg_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_o |=> tg_pulse_o);

endmodule

// File: rtl/ita_phase_seq.sv
// Module: ita_phase_seq
// Steps the line phase: a fast line is followed by a slow line, and a
// slow line is followed by a new pair, which starts fast only when the
// new ratio is above 1. It asks for a configuration load at each pair
// start.
// Assumes: line_end_i is a one-cycle strobe on the last pixel of a line.
module ita_phase_seq
    import ita_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   line_end_i,
    input  logic   split_i,
    input  logic   split_next_i,
    output phase_e phase_o,
    output logic   load_o
);

    assign load_o = line_end_i && (phase_o == PH_SLOW);

    // Purpose: choose the timebase of the next line at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= split_next_i ? PH_FAST : PH_SLOW;
        end else if (line_end_i) begin
            if (phase_o == PH_FAST) begin
                phase_o <= PH_SLOW;
            end else begin
                phase_o <= split_next_i ? PH_FAST : PH_SLOW;
            end
        end
    end

    // R5: a discard line is always followed by a kept line
    assert_fast_then_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end_i && phase_o == PH_FAST) |=> (phase_o == PH_SLOW));

    // R6: with alternation off, every line runs on the slow timebase
    assert_no_split_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !split_i |-> (phase_o == PH_SLOW));

    // R7: the phase moves only at a line boundary
    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end_i |=> $stable(phase_o));

endmodule

// File: rtl/ita_timebase.sv
// Module: ita_timebase (top)
// Alternating fast/slow line timebase for a line-scan sensor. It ties
// together the configuration latch, the pixel divider, the line counter
// and the phase sequencer, and it drives the sensor timing strobes.
// Assumes: synchronous active-low reset held for at least one edge.
module ita_timebase
    import ita_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter int LEN_W    = 8,
    parameter int ITA_W    = 3,
    parameter int MIN_KEEP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] base_div_i,
    input  logic [LEN_W-1:0] line_len_i,
    input  logic [ITA_W-1:0] ita_i,
    output logic             pix_en_o,
    output logic             tg_pulse_o,
    output logic             discard_o,
    output logic             line_start_o
);

    localparam int SDIV_W = DIV_W + ITA_W;

    logic [SDIV_W-1:0] fast_div;
    logic [SDIV_W-1:0] slow_div;
    logic [SDIV_W-1:0] cur_period;
    logic [LEN_W-1:0]  last_pix;
    logic              split_q;
    logic              split_next;
    logic              load;
    logic              line_end;
    logic              first_pix;
    phase_e            phase;

    ita_cfg_latch #(
        .DIV_W    (DIV_W),
        .LEN_W    (LEN_W),
        .ITA_W    (ITA_W),
        .MIN_KEEP (MIN_KEEP)
    ) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .base_div_i   (base_div_i),
        .line_len_i   (line_len_i),
        .ita_i        (ita_i),
        .fast_div_o   (fast_div),
        .slow_div_o   (slow_div),
        .last_pix_o   (last_pix),
        .split_o      (split_q),
        .split_next_o (split_next)
    );

    // Purpose: pick the pixel period of the timebase in use on this line.
    always_comb begin
        cur_period = (phase == PH_FAST) ? fast_div : slow_div;
    end

    ita_pix_div #(
        .SDIV_W (SDIV_W)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (cur_period),
        .pix_en_o (pix_en_o)
    );

    ita_line_ctr #(
        .LEN_W (LEN_W)
    ) line_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en_i    (pix_en_o),
        .last_pix_i  (last_pix),
        .line_end_o  (line_end),
        .first_pix_o (first_pix),
        .tg_pulse_o  (tg_pulse_o)
    );

    ita_phase_seq seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_end_i   (line_end),
        .split_i      (split_q),
        .split_next_i (split_next),
        .phase_o      (phase),
        .load_o       (load)
    );

    assign discard_o    = (phase == PH_FAST);
    assign line_start_o = pix_en_o && first_pix;

    // R7: the discard flag changes only on a transfer-pulse cycle
    assert_discard_on_tg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tg_pulse_o |-> (discard_o == (phase == PH_FAST)) ##0 1'b1 |=> (tg_pulse_o || $stable(discard_o)));

    // R8: the line-start strobe comes only with a pixel enable
    assert_start_with_pix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> pix_en_o);

    // R9: a configuration load happens only at the end of a kept line
    assert_load_after_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (line_end && !discard_o));

endmodule

// File: tb/ita_timebase_tb_top.sv
// Bench: sweeps divider, ratio and line length. It changes the
// configuration part-way through every run and compares each output on
// every cycle against an arithmetic model built from the requirements.
module ita_timebase_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] base_div = '0;
    logic [7:0] line_len = '0;
    logic [2:0] ita = '0;
    logic       pix_en, tg_pulse, discard, line_start;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc_total = 0;

    always #2 clk = ~clk;

    ita_timebase dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_div_i   (base_div),
        .line_len_i   (line_len),
        .ita_i        (ita),
        .pix_en_o     (pix_en),
        .tg_pulse_o   (tg_pulse),
        .discard_o    (discard),
        .line_start_o (line_start)
    );

    // Model state, updated from the requirement rules only.
    int m_f, m_s, m_len, m_c, m_p;
    bit m_fast;

    task automatic chk(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (base=%0d ita=%0d len=%0d)",
                     what, act, exp, base_div, ita, line_len);
        end
    endtask

    // R2/R3: clamp the inputs and derive the fast and kept periods.
    task automatic m_latch();
        int ie, be, mf;
        ie = (ita == 0) ? 1 : int'(ita);
        be = (base_div == 0) ? 1 : int'(base_div);
        mf = (6 + ie - 1) / ie;
        m_f = (be > mf) ? be : mf;
        m_s = m_f * ie;
        m_len = (line_len == 0) ? 1 : int'(line_len);
        m_fast = (ie > 1);
    endtask

    task automatic m_advance();
        int d;
        d = m_fast ? m_f : m_s;
        if (m_c == d - 1) begin
            m_c = 0;
            if (m_p == m_len - 1) begin
                m_p = 0;
                if (m_fast) m_fast = 1'b0;
                else m_latch();                     // R9: pair start only
            end else begin
                m_p++;
            end
        end else begin
            m_c++;
        end
    endtask

    task automatic run_cfg(input int b, input int l, input int i,
                           input int b2, input int l2, input int i2, input int n);
        int d, cyc, pc, prev_len, prev_l;
        bit have_prev;
        @(negedge clk);
        rst_n = 1'b0;
        base_div = 4'(b); line_len = 8'(l); ita = 3'(i);
        @(negedge clk);
        m_latch(); m_c = 0; m_p = 0;                // R1: sampled in reset
        rst_n = 1'b1;
        #1;
        chk(int'(tg_pulse), 1, "R1 tg_pulse first cycle");
        chk(int'(discard), int'(m_fast), "R1 discard first cycle");
        have_prev = 0; cyc = 0; pc = 0; prev_len = 0; prev_l = 0;
        for (int k = 0; k < n; k++) begin
            d = m_fast ? m_f : m_s;
            chk(int'(pix_en), int'(m_c == d - 1), "R4 pix_en");
            chk(int'(tg_pulse), int'(m_c == 0 && m_p == 0), "R7 tg_pulse");
            chk(int'(discard), int'(m_fast), m_fast ? "R5 discard" : "R6 discard");
            chk(int'(line_start), int'(m_c == d - 1 && m_p == 0), "R8 line_start");
            if (tg_pulse) begin
                if (have_prev) begin
                    chk(cyc, prev_len, "R3 line length in cycles");
                    chk(pc, prev_l, "R8 pixels per line");
                end
                have_prev = 1;
                cyc = 0; pc = 0;
                prev_len = m_len * d;
                prev_l = m_len;
            end
            cyc++;
            pc += int'(pix_en);
            if (k == 3) begin                       // R9: mid-pair change
                base_div = 4'(b2); line_len = 8'(l2); ita = 3'(i2);
            end
            m_advance();
            @(negedge clk);
            #1;
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc_total);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int bl[5];
        int il[5];
        int ll[3];
        bl = '{0, 1, 2, 3, 7};
        il = '{0, 1, 2, 3, 5};
        ll = '{0, 1, 3};
        for (int bi = 0; bi < 5; bi++) begin
            for (int ii = 0; ii < 5; ii++) begin
                for (int li = 0; li < 3; li++) begin
                    run_cfg(bl[bi], ll[li], il[ii],
                            bl[(bi + 2) % 5], ll[(li + 1) % 3], il[(ii + 3) % 5], 260);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule